// File: doc/BRIEF.md
# Time Base and Watchdog Interrupt Generator

This block turns a 32 kHz system clock into two slow timing services that share one counter: a periodic time base that toggles at a selectable rate between 1 Hz and 128 Hz, and a watchdog that raises a sticky flag when software has not cleared it within a selectable window. One 3-bit rate code sets both. The chosen time base rate and the watchdog window always move together, so a faster time base always means a shorter watchdog window. The shared counter is an 8-bit divide-by-256 prescaler followed by a 7-bit divider chain.

Software drives the block through decoded commands, one per cycle. Each command enables, disables or clears the time base, the watchdog or the interrupt output, or loads a new rate code. The result is an active-low interrupt level meant for an open-drain pad driver. The time base square wave, the latched watchdog flag, or both, can pull it low, and only while the interrupt output is enabled.

Top module: `tbase_wdog`

## Requirements
- R1: After reset the time base, the watchdog and the interrupt output are all disabled, the watchdog flag is clear, the rate code is 7 and `irq_n` is high.
- R2: With the time base and the interrupt output enabled, `irq_n` is a 50 % square wave. Counting from a time base clear, it is high for the first half of each period and low for the second half.
- R3: A rate code c (0..7) loaded by opcode 8 (argument in `cmd_arg`) sets the time base period to 256·2^(7−c) system clocks, which is 128 Hz for c=7 and 1 Hz for c=0. The new code applies from the edge that loads it.
- R4: While the watchdog is enabled it counts completed periods of the shared counter at the current rate. The 4th completion sets the watchdog flag, which gives 1/32 s at c=7 and 4 s at c=0. While the watchdog is disabled, completions are not counted.
- R5: Once set, the watchdog flag holds `irq_n` low, whenever the interrupt output is enabled, until a watchdog clear (opcode 5) or an interrupt disable (opcode 6) clears it.
- R6: The three enables are independent. Opcodes are: 0 time base off, 1 time base on, 3 watchdog off, 4 watchdog on, 6 interrupt off, 7 interrupt on. `irq_n` is low exactly when the interrupt output is enabled and either the enabled time base wave is high or the watchdog flag is set.
- R7: A time base clear (opcode 2) zeroes the shared counter at the edge that takes it. A period completion falling on that same edge is not counted by the watchdog.
- R8: A watchdog clear (opcode 5) zeroes the watchdog count and flag at the edge that takes it, and it wins over a timeout on that same edge.
- R9: Nothing changes state when `cmd_valid` is low, or when the opcode is 9 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_arg | input | RATE_W | Rate code for opcode 8 |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
Two collisions are the focus. The first is a time base clear that arrives on the edge where the shared counter would complete a period the watchdog is counting. The second is a watchdog clear that arrives on the edge where the 4th completion would set the flag. The bench follows its own model to find the cycle just before such an edge and issues the clear then. It then judges `irq_n` against the model on every following cycle: a completion that is wrongly counted or a timeout that is wrongly latched shows up later as an early or extra interrupt.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
   typedef enum logic [3:0] {
      OP_TB_OFF   = 4'd0,
      OP_TB_ON    = 4'd1,
      OP_TB_CLR   = 4'd2,
      OP_WD_OFF   = 4'd3,
      OP_WD_ON    = 4'd4,
      OP_WD_CLR   = 4'd5,
      OP_IRQ_OFF  = 4'd6,
      OP_IRQ_ON   = 4'd7,
      OP_SET_RATE = 4'd8
   } tbw_op_e;
endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
   import tbw_pkg::*;
#(
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [RATE_W-1:0] cmd_arg,
   output logic              tb_en,
   output logic              wd_en,
   output logic              irq_en,
   output logic [RATE_W-1:0] rate,
   output logic              tb_clr,
   output logic              wd_clr,
   output logic              irq_off
);
   logic is_op [16];

   for (genvar k = 0; k < 16; k++) begin : g_dec
      assign is_op[k] = cmd_valid && (cmd_op == 4'(k));
   end

   assign tb_clr  = is_op[OP_TB_CLR];
   assign wd_clr  = is_op[OP_WD_CLR];
   assign irq_off = is_op[OP_IRQ_OFF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_en  <= 1'b0;
         wd_en  <= 1'b0;
         irq_en <= 1'b0;
         rate   <= '1;
      end else begin
         if (is_op[OP_TB_ON])        tb_en  <= 1'b1;
         else if (is_op[OP_TB_OFF])  tb_en  <= 1'b0;
         if (is_op[OP_WD_ON])        wd_en  <= 1'b1;
         else if (is_op[OP_WD_OFF])  wd_en  <= 1'b0;
         if (is_op[OP_IRQ_ON])       irq_en <= 1'b1;
         else if (is_op[OP_IRQ_OFF]) irq_en <= 1'b0;
         if (is_op[OP_SET_RATE])     rate   <= cmd_arg;
      end
   end

   // R9: an idle command port leaves all control state untouched
   assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable({tb_en, wd_en, irq_en, rate}));
endmodule

// File: rtl/tbw_divider.sv
module tbw_divider #(
   parameter int PRE_W  = 8,
   parameter int DIV_W  = 7,
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [RATE_W-1:0] rate,
   output logic              wave,
   output logic              period_done
);
   localparam int CNT_W  = PRE_W + DIV_W;
   localparam int N_TAPS = DIV_W + 1;

   logic [CNT_W-1:0]  cnt_q;
   logic [N_TAPS-1:0] tap_vec;
   logic [N_TAPS-1:0] wrap_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   // one tap per rate code: code g uses bit (PRE_W-1+DIV_W-g)
   for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
      localparam int BIT = PRE_W - 1 + DIV_W - g;
      assign tap_vec[g]  = cnt_q[BIT];
      assign wrap_vec[g] = &cnt_q[BIT:0];
   end

   assign wave        = tap_vec[rate];
   assign period_done = wrap_vec[rate] && !clr;

   // R7: a clear leaves the shared counter at zero after the edge
   assert_clr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
   // R2: the selected tap is low right after every period wrap
   assert_wrap_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_vec[rate] && $stable(rate)) |=> (!wave || $changed(rate)));
endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
   parameter int PERIODS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   input  logic flag_clr,
   input  logic period_done,
   output logic flag
);
   localparam int CW = (PERIODS > 1) ? $clog2(PERIODS) : 1;

   logic last;
   logic step;

   assign step = en && period_done;

   if (PERIODS == 1) begin : g_single
      assign last = 1'b1;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt_q <= '0;
         else if (clr)  cnt_q <= '0;
         else if (step) cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
      assign last = (cnt_q == CW'(PERIODS - 1));
      // R8: a watchdog clear always restarts the count
      assert_clr_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (cnt_q == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag <= 1'b0;
      else if (clr || flag_clr)  flag <= 1'b0;
      else if (step && last)     flag <= 1'b1;
   end

   // R5: the flag holds until one of its two clears
   assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr && !flag_clr) |=> flag);
   // R8: clear wins over a coincident timeout
   assert_clr_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag);
   // R4: the flag only rises on an enabled period completion
   assert_rise_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(en && period_done));
endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog
   import tbw_pkg::*;
#(
   parameter int PRE_W   = 8,
   parameter int DIV_W   = 7,
   parameter int PERIODS = 4,
   parameter int RATE_W  = $clog2(DIV_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [RATE_W-1:0] cmd_arg,
   output logic              irq_n
);
   if (PRE_W < 1) begin : g_bad_pre
      $error("PRE_W must be at least 1");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end
   if ((DIV_W + 1) != (1 << RATE_W)) begin : g_bad_rate
      $error("DIV_W+1 must equal 2**RATE_W");
   end
   if (PERIODS < 1) begin : g_bad_per
      $error("PERIODS must be at least 1");
   end

   logic              tb_en, wd_en, irq_en;
   logic              tb_clr, wd_clr, irq_off;
   logic [RATE_W-1:0] rate;
   logic              wave, period_done, flag;

   tbw_ctrl #(.RATE_W(RATE_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_arg(cmd_arg), .tb_en(tb_en), .wd_en(wd_en), .irq_en(irq_en),
      .rate(rate), .tb_clr(tb_clr), .wd_clr(wd_clr), .irq_off(irq_off)
   );

   tbw_divider #(.PRE_W(PRE_W), .DIV_W(DIV_W), .RATE_W(RATE_W)) div_i (
      .clk(clk), .rst_n(rst_n), .clr(tb_clr), .rate(rate),
      .wave(wave), .period_done(period_done)
   );

   tbw_watchdog #(.PERIODS(PERIODS)) wdog_i (
      .clk(clk), .rst_n(rst_n), .en(wd_en), .clr(wd_clr),
      .flag_clr(irq_off), .period_done(period_done), .flag(flag)
   );

   assign irq_n = !(irq_en && ((tb_en && wave) || flag));

   // R6: a disabled interrupt output never pulls low
   assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> irq_n);
   // R1: the first cycle after reset is quiet
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> irq_n);
endmodule

// File: tb/tbase_wdog_tb_top.sv
`timescale 1ns/1ps
module tbase_wdog_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cv = 1'b0;
   logic [3:0] cop = 4'd0;
   logic [2:0] carg = 3'd0;
   logic       irq_n;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_tcnt, m_wcnt, m_code;
   bit m_tb, m_wd, m_irq, m_flag;

   always #5 clk = ~clk;

   tbase_wdog dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cv), .cmd_op(cop),
      .cmd_arg(carg), .irq_n(irq_n)
   );

   function automatic int period_of(int code);
      return 256 << (7 - code);
   endfunction

   function automatic bit exp_irq_n();
      int p;
      bit w;
      p = period_of(m_code);
      w = (m_tcnt % p) >= (p / 2);
      return !(m_irq && ((m_tb && w) || m_flag));
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      int p;
      bit done, tclr;
      if (!rst_n) begin
         m_tcnt = 0; m_wcnt = 0; m_code = 7;
         m_tb = 0; m_wd = 0; m_irq = 0; m_flag = 0;
      end else begin
         p    = period_of(m_code);
         tclr = cv && cop == 4'd2;
         done = ((m_tcnt % p) == p - 1) && !tclr;
         if (cv && cop == 4'd5) begin
            m_wcnt = 0; m_flag = 0;
         end else begin
            if (m_wd && done) begin
               if (m_wcnt == 3) begin m_wcnt = 0; m_flag = 1; end
               else m_wcnt++;
            end
            if (cv && cop == 4'd6) m_flag = 0;
         end
         m_tcnt = tclr ? 0 : (m_tcnt + 1) % 32768;
         if (cv) begin
            case (cop)
               4'd0: m_tb = 0;
               4'd1: m_tb = 1;
               4'd3: m_wd = 0;
               4'd4: m_wd = 1;
               4'd6: m_irq = 0;
               4'd7: m_irq = 1;
               4'd8: m_code = int'(carg);
               default: ;
            endcase
         end
      end
   end

   task automatic check(string req, bit got, bit exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s cycle %0d: irq_n=%b expected %b", req, cyc, got, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) check(cur_req, irq_n, exp_irq_n());
   end

   // every task below is entered and left at a falling edge
   task automatic cmd(int op, int arg = 0);
      cv = 1'b1; cop = 4'(op); carg = 3'(arg);
      @(negedge clk);
      cv = 1'b0; cop = 4'd0; carg = 3'd0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : wdog
      repeat (190000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      finish_run();
   end

   initial begin
      idle(3);
      check("R1", irq_n, 1'b1);
      rst_n = 1'b1;
      idle(5);
      check("R1", irq_n, 1'b1);
      // R1: default rate 7 gives a 256-cycle period
      cur_req = "R1";
      cmd(7); cmd(1); idle(600);

      // R2: half high, half low after a clear
      cur_req = "R2";
      cmd(2); idle(100);
      check("R2", irq_n, 1'b1);
      idle(100);
      check("R2", irq_n, 1'b0);
      idle(600);

      // R3: rate selection across codes
      cur_req = "R3";
      cmd(8, 5); cmd(2); idle(2200);
      cmd(8, 0); idle(33000);
      cmd(8, 2); idle(17000);
      cmd(8, 7); idle(600);

      // R6: watchdog flag while interrupt output is off, time base off
      cur_req = "R6";
      cmd(0); cmd(6); cmd(5); cmd(2); cmd(4); idle(1200);
      check("R6", irq_n, 1'b1);
      cmd(7); idle(2);
      check("R6", irq_n, 1'b0);

      // R5: flag stays until interrupt disable or watchdog clear
      cur_req = "R5";
      idle(3000);
      check("R5", irq_n, 1'b0);
      cmd(6); cmd(7); idle(20);
      check("R5", irq_n, 1'b1);
      idle(1200);
      cmd(5); idle(100);

      // R4: timeout at rate 6, then no counting while disabled
      cur_req = "R4";
      cmd(8, 6); cmd(2); cmd(5); idle(2100);
      check("R4", irq_n, 1'b0);
      cmd(3); cmd(5); idle(3000);
      check("R4", irq_n, 1'b1);

      // R7: time base clear on the completing edge
      cur_req = "R7";
      cmd(8, 7); cmd(4); cmd(5);
      for (int k = 0; k < 6; k++) begin
         while ((m_tcnt % 256) != 255) @(negedge clk);
         cmd(2);
         idle(37);
      end
      idle(1500);

      // R8: watchdog clear on the timeout edge
      cur_req = "R8";
      cmd(5);
      while (!(m_wcnt == 3 && (m_tcnt % 256) == 255)) @(negedge clk);
      cmd(5); idle(10);
      check("R8", irq_n, 1'b1);
      idle(1100);

      // R9: idle port and unused opcodes leave state alone
      cur_req = "R9";
      cmd(3); cmd(5); cmd(0); idle(5);
      cv = 1'b0; cop = 4'd1; idle(3);
      cop = 4'd4; idle(3);
      cop = 4'd0;
      for (int op = 9; op < 16; op++) cmd(op, 3);
      idle(3000);
      check("R9", irq_n, 1'b1);

      finish_run();
   end
endmodule